// File: doc/BRIEF.md
# Seven-operand carry-save reducer

This block adds seven unsigned operands of equal width without resolving any carries. It returns two rows whose sum is the exact total of the seven inputs. A final carry-propagate adder, or a further reduction stage, turns those two rows into one binary number. Typical users are multiplier partial-product trees, dot-product accumulators and wide checksum units.

The reducer is built from one bit-slice that is copied across the width. Each slice counts the seven operand bits of its column, using full and half adders. It hands one transfer bit to the next column and a pair of transfer bits to the column two places up. It then folds the transfers arriving from below into one bit of each output row.

The outgoing transfers depend only on the slice's own operand bits. For that reason no carry chain forms across columns, and the logic depth is the same for any width. Two operand-free slices above the top column take in the transfers that leave the top columns. The rows are then registered once, with a synchronous active-low reset.

Top module: `csa7_reduce`

## Requirements
- R1: When rst_n is low at a rising edge of clk, both output rows read zero after that edge, whatever values the operands hold.
- R2: When rst_n is high at a rising edge, then after that edge row_sum + row_carry equals the exact sum of the seven operands sampled at that edge. The addition is taken one bit wider than the rows, and the result holds until the next edge.
- R3: Each row is OP_W+3 bits wide. Seven operands that are all ones give a total of 7·(2^OP_W − 1), and no bit of it is lost.
- R4: Bit 0 of row_carry is always zero.
- R5: When all seven operands hold a single 1 in the same bit position p and zeros elsewhere, the rows add to 7·2^p. This holds for every p from 0 to OP_W−1, so transfers that leave the top column are kept.
- R6: In every slice, the two transfer bits sent two columns up are never both 1. This lets the receiving slice absorb its three incoming transfers into one row-sum bit and one row-carry bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rows update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears both rows |
| op0 | input | OP_W | Operand 0, unsigned |
| op1 | input | OP_W | Operand 1, unsigned |
| op2 | input | OP_W | Operand 2, unsigned |
| op3 | input | OP_W | Operand 3, unsigned |
| op4 | input | OP_W | Operand 4, unsigned |
| op5 | input | OP_W | Operand 5, unsigned |
| op6 | input | OP_W | Operand 6, unsigned |
| row_sum | output | OP_W+3 | Registered first carry-save row, weight 2^i at bit i |
| row_carry | output | OP_W+3 | Registered second carry-save row; bit 0 is always zero |

## Verification
All-zero and all-ones operands mark the two ends of the range. The all-ones case shows that the widened rows keep the topmost transfer. Single-column patterns put seven ones into one position at a time, so each slice at each height drives its own transfer bits with no help from its neighbours. A wrong transfer weight or a dropped top transfer then shows up as a specific wrong total. Single operands at full scale, alternating bit patterns and several hundred random vectors then mix the operand, transfer and row paths, and a reset asserted mid-run shows that held operands cannot leak into the cleared rows.

// File: rtl/csa7_pkg.sv
// Shared constants and types for the seven-operand carry-save reducer.
// Assumes unsigned operands of a common width.
package csa7_pkg;

    // Number of operands folded per column.
    localparam int unsigned N_OPS = 7;

    // Extra row bits needed to hold the sum of N_OPS full-scale operands.
    localparam int unsigned GROW_BITS = $clog2(N_OPS + 1);

    // Transfer bits leaving one slice: one to the next column,
    // a pair to the column two places up.
    typedef struct packed {
        logic       up1;
        logic [1:0] up2;
    } xfer_t;

endpackage

// File: rtl/csa_fa.sv
// Full adder used as a 3:2 counter.
// Counts the ones among three equal-weight bits: sum keeps the weight,
// carry has twice that weight. Purely combinational.
module csa_fa (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic sum,
    output logic carry
);

    // Parity and majority of the three inputs.
    always_comb begin
        sum   = a ^ b ^ c;
        carry = (a & b) | (a & c) | (b & c);
    end

endmodule

// File: rtl/csa_ha.sv
// Half adder used as a 2:2 counter.
// Counts the ones among two equal-weight bits. Purely combinational.
module csa_ha (
    input  logic a,
    input  logic b,
    output logic sum,
    output logic carry
);

    // Parity and conjunction of the two inputs.
    always_comb begin
        sum   = a ^ b;
        carry = a & b;
    end

endmodule

// File: rtl/csa7_slice.sv
// One column of the seven-operand reducer.
// Takes the seven operand bits of column i, one transfer bit from column i-1
// and a transfer pair from column i-2. Produces the row-sum bit of column i,
// the row-carry bit of column i+1, and fresh transfers for i+1 and i+2.
// The outgoing transfers are computed from the operand bits alone. The
// incoming pair is assumed never to be both 1, which every slice guarantees.
module csa7_slice
    import csa7_pkg::*;
(
    input  logic [N_OPS-1:0] col_bits,
    input  logic             in_up1,
    input  logic [1:0]       in_up2,
    output logic             row0_bit,
    output logic             row1_bit,
    output xfer_t            xfer_out
);

    // Operand counting network (weight 1 -> weights 2 and 4).
    logic s_a, c_a, s_b, c_b, s_c, c_c;
    logic s_d, c_d, s_e, c_e;
    // Transfer absorption network.
    logic s_f, c_f, c_g;

    // First two 3:2 counters on operand bits 0..5.
    csa_fa u_fa_a (.a(col_bits[0]), .b(col_bits[1]), .c(col_bits[2]), .sum(s_a), .carry(c_a));
    csa_fa u_fa_b (.a(col_bits[3]), .b(col_bits[4]), .c(col_bits[5]), .sum(s_b), .carry(c_b));
    // Third counter folds both partial sums with operand bit 6.
    csa_fa u_fa_c (.a(s_a), .b(s_b), .c(col_bits[6]), .sum(s_c), .carry(c_c));

    // Weight-2 bits c_a, c_b, c_c reduced by two half adders:
    // one weight-2 bit goes up one column, two weight-4 bits go up two.
    csa_ha u_ha_d (.a(c_a), .b(c_b), .sum(s_d), .carry(c_d));
    csa_ha u_ha_e (.a(s_d), .b(c_c), .sum(s_e), .carry(c_e));

    // Incoming transfers joined with the residual operand bit.
    csa_fa u_fa_f (.a(s_c), .b(in_up1), .c(in_up2[0]), .sum(s_f), .carry(c_f));
    csa_ha u_ha_g (.a(s_f), .b(in_up2[1]), .sum(row0_bit), .carry(c_g));

    // Route results: the two weight-2 carries are exclusive, so one bit holds them.
    always_comb begin
        row1_bit        = c_f ^ c_g;
        xfer_out.up1    = s_e;
        xfer_out.up2[0] = c_d;
        xfer_out.up2[1] = c_e;
    end

    // Guard the absorption step against an incoming pair that cannot fit.
    always_comb begin
        if (!$isunknown(in_up2)) begin
            // R6
            up2_pair_excl_chk: assert ($onehot0(in_up2));
        end
        if (!$isunknown({c_f, c_g})) begin
            // R6
            row1_merge_chk: assert (!(c_f && c_g));
        end
    end

endmodule

// File: rtl/csa7_array.sv
// Column array of the seven-operand reducer.
// Places one slice per operand column plus two operand-free slices on top,
// which take in the transfers leaving the highest columns. Produces two rows
// of OP_W+3 bits whose sum equals the operand total. Combinational, and the
// depth does not depend on OP_W.
module csa7_array
    import csa7_pkg::*;
#(
    parameter int unsigned OP_W = 16,
    localparam int unsigned ROW_W = OP_W + GROW_BITS
) (
    input  logic [N_OPS-1:0][OP_W-1:0] ops,
    output logic [ROW_W-1:0]           row0,
    output logic [ROW_W-1:0]           row1
);

    // Operand columns plus the two padding columns.
    localparam int unsigned N_SLICE = OP_W + 2;

    xfer_t             xfer     [N_SLICE];
    logic [N_SLICE-1:0] r0_bits;
    logic [N_SLICE-1:0] r1_bits;

    for (genvar i = 0; i < N_SLICE; i++) begin : g_col
        logic [N_OPS-1:0] col;
        logic             up1_in;
        logic [1:0]       up2_in;

        // Gather the column bits, or zeros for a padding column.
        if (i < OP_W) begin : g_live
            for (genvar k = 0; k < N_OPS; k++) begin : g_bit
                assign col[k] = ops[k][i];
            end
        end else begin : g_pad
            assign col = '0;
        end

        // One-column transfer, tied off at the bottom.
        if (i >= 1) begin : g_up1
            assign up1_in = xfer[i-1].up1;
        end else begin : g_up1_tie
            assign up1_in = 1'b0;
        end

        // Two-column transfer pair, tied off in the two lowest columns.
        if (i >= 2) begin : g_up2
            assign up2_in = xfer[i-2].up2;
        end else begin : g_up2_tie
            assign up2_in = 2'b00;
        end

        csa7_slice u_slice (
            .col_bits (col),
            .in_up1   (up1_in),
            .in_up2   (up2_in),
            .row0_bit (r0_bits[i]),
            .row1_bit (r1_bits[i]),
            .xfer_out (xfer[i])
        );
    end

    // Assemble rows: the row-carry bit of slice i has weight 2^(i+1).
    always_comb begin
        row0 = {1'b0, r0_bits};
        row1 = {r1_bits, 1'b0};
    end

endmodule

// File: rtl/csa7_reduce.sv
// Top of the seven-operand carry-save reducer.
// Feeds seven unsigned OP_W-bit operands to the column array and registers
// the two resulting rows. Latency is one clock. Reset is synchronous and
// active low and clears both rows.
module csa7_reduce
    import csa7_pkg::*;
#(
    parameter int unsigned OP_W = 16,
    localparam int unsigned ROW_W = OP_W + GROW_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op0,
    input  logic [OP_W-1:0]  op1,
    input  logic [OP_W-1:0]  op2,
    input  logic [OP_W-1:0]  op3,
    input  logic [OP_W-1:0]  op4,
    input  logic [OP_W-1:0]  op5,
    input  logic [OP_W-1:0]  op6,
    output logic [ROW_W-1:0] row_sum,
    output logic [ROW_W-1:0] row_carry
);

    logic [N_OPS-1:0][OP_W-1:0] ops;
    logic [ROW_W-1:0]           row0_d;
    logic [ROW_W-1:0]           row1_d;

    // Bundle the operand ports for the array.
    always_comb begin
        ops = {op6, op5, op4, op3, op2, op1, op0};
    end

    csa7_array #(.OP_W(OP_W)) u_array (
        .ops  (ops),
        .row0 (row0_d),
        .row1 (row1_d)
    );

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_sum   <= '0;
            row_carry <= '0;
        end else begin
            row_sum   <= row0_d;
            row_carry <= row1_d;
        end
    end

    // Reference total used only by the checks below.
    logic [ROW_W:0] op_total;
    always_comb begin
        op_total = '0;
        for (int k = 0; k < N_OPS; k++) begin
            op_total = op_total + {{(GROW_BITS + 1){1'b0}}, ops[k]};
        end
    end

    // R2
    sum_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, row0_d} + {1'b0, row1_d}) == op_total);

    // R2
    reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (row_sum == $past(row0_d)) && (row_carry == $past(row1_d)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (row_sum == '0) && (row_carry == '0));

    // R4
    carry_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_carry[0] == 1'b0);

endmodule

// File: tb/csa7_reduce_bench.sv
// Scoreboard bench: the driver pushes the expected total for each vector,
// the monitor pops it one clock later and compares it with the rows.
module csa7_reduce_bench;

    localparam int unsigned OP_W  = 16;
    localparam int unsigned ROW_W = OP_W + 3;
    localparam int unsigned CHK_W = ROW_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [OP_W-1:0]  op0 = '0, op1 = '0, op2 = '0, op3 = '0, op4 = '0, op5 = '0, op6 = '0;
    logic [ROW_W-1:0] row_sum;
    logic [ROW_W-1:0] row_carry;

    int errors = 0;
    int checks = 0;
    logic [CHK_W-1:0] exp_q [$];
    string            tag_q [$];

    always #10 clk = ~clk;

    csa7_reduce #(.OP_W(OP_W)) u_csa7_reduce (
        .clk(clk), .rst_n(rst_n),
        .op0(op0), .op1(op1), .op2(op2), .op3(op3), .op4(op4), .op5(op5), .op6(op6),
        .row_sum(row_sum), .row_carry(row_carry)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge and record its expected total.
    task automatic drive(input logic [OP_W-1:0] a0, input logic [OP_W-1:0] a1,
                         input logic [OP_W-1:0] a2, input logic [OP_W-1:0] a3,
                         input logic [OP_W-1:0] a4, input logic [OP_W-1:0] a5,
                         input logic [OP_W-1:0] a6, input string req);
        logic [CHK_W-1:0] t;
        @(negedge clk);
        op0 = a0; op1 = a1; op2 = a2; op3 = a3; op4 = a4; op5 = a5; op6 = a6;
        t = CHK_W'(a0) + CHK_W'(a1) + CHK_W'(a2) + CHK_W'(a3)
          + CHK_W'(a4) + CHK_W'(a5) + CHK_W'(a6);
        exp_q.push_back(t);
        tag_q.push_back(req);
    endtask

    // Monitor: compare each registered result against the scoreboard.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [CHK_W-1:0] e;
            logic [CHK_W-1:0] got;
            string            t;
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {1'b0, row_sum} + {1'b0, row_carry};
            check(got == e, t, "row total", 64'(got), 64'(e));
            // R4: lowest row-carry bit stays clear
            check(row_carry[0] == 1'b0, "R4", "row_carry[0]", 64'(row_carry[0]), 64'd0);
        end
    end

    task automatic wait_drain();
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #5;
    endtask

    // Hold reset with busy operands and check that both rows stay clear.
    task automatic reset_check(input string what);
        @(negedge clk);
        rst_n = 1'b0;
        op0 = '1; op1 = '1; op2 = '1; op3 = '1; op4 = '1; op5 = '1; op6 = '1;
        @(posedge clk);
        #5;
        check(row_sum == '0, "R1", {what, " row_sum"}, 64'(row_sum), 64'd0);
        check(row_carry == '0, "R1", {what, " row_carry"}, 64'(row_carry), 64'd0);
        @(negedge clk);
        op3 = 16'h1234;
        @(posedge clk);
        #5;
        check(row_sum == '0 && row_carry == '0, "R1", {what, " held"},
              64'(row_sum | row_carry), 64'd0);
    endtask

    initial begin
        logic [OP_W-1:0] ones;
        ones = '1;
        reset_check("power-up");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all operands zero
        drive('0, '0, '0, '0, '0, '0, '0, "R2");
        // R3: full-scale total 7*(2^OP_W-1)
        drive(ones, ones, ones, ones, ones, ones, ones, "R3");
        // R5 R6: seven ones in a single column, every column including the top
        for (int p = 0; p < OP_W; p++) begin
            logic [OP_W-1:0] b;
            b = OP_W'(1) << p;
            drive(b, b, b, b, b, b, b, "R5,R6");
        end
        // R2: one operand at full scale, the others zero
        for (int k = 0; k < 7; k++) begin
            drive(k == 0 ? ones : '0, k == 1 ? ones : '0, k == 2 ? ones : '0,
                  k == 3 ? ones : '0, k == 4 ? ones : '0, k == 5 ? ones : '0,
                  k == 6 ? ones : '0, "R2");
        end
        // R2: alternating patterns
        drive(16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, "R2");
        drive(16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, "R2");
        drive(16'h8001, 16'h8001, 16'h8001, 16'h0000, 16'hFFFF, 16'h7FFE, 16'h8001, "R2");
        // R2: random vectors
        for (int n = 0; n < 300; n++) begin
            drive(OP_W'($urandom), OP_W'($urandom), OP_W'($urandom), OP_W'($urandom),
                  OP_W'($urandom), OP_W'($urandom), OP_W'($urandom), "R2");
        end
        wait_drain();

        // R1: reset in mid-run clears the rows, then operation resumes
        reset_check("mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        drive(ones, ones, ones, ones, ones, ones, ones, "R3");
        drive(16'h0001, '0, '0, '0, '0, '0, '0, "R2");
        wait_drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule